// File: doc/BRIEF.md
# Execution Unit Error Monitor

This block watches the control traffic around a cipher execution unit and turns protocol violations into a sticky error record, an interrupt and a halt request. It observes host register reads and writes, push and pop strobes with occupancy counts for a 64-bit input FIFO and a 64-bit output FIFO, and a one-cycle processing-done event. It does not hold the FIFO storage or the cipher datapath. It only decides when one of nine error conditions has happened.

The host sees a small register window. Word offset 0 is the mode register and offset 1 is the data-size register. Writes to both are watched, and reads of both return zero from this block. Offset 2 holds the error status, which the host clears by writing ones. Offset 3 holds the error mask. Each error owns one bit at the same position in the status and mask registers, inside bits 55 to 63 of a 64-bit word. A set mask bit makes its error invisible: the status bit is not recorded and the engine keeps running. Any status bit whose mask bit is clear drives both the interrupt and the halt output.

Top module: `eu_err_mon`

## Requirements
- R1: After reset the status register and the mask register read as zero, and errIrq and engineHalt are low.
- R2: An error whose mask bit is set leaves its status bit clear and does not raise errIrq or engineHalt.
- R3: When an unmasked error is detected, its status bit reads as set from the next clock, and errIrq and engineHalt are high in that same cycle.
- R4: Writing the data-size register (offset 1) with a value whose low 6 bits are not all zero (not a multiple of 64 bits) sets status bit 56. A multiple of 64 sets nothing.
- R5: Writing the mode register (offset 0) with any bit set outside the legal field (bits 2:0 by default) sets status bit 60.
- R6: A host read or write to any word offset from 4 up to the end of the window sets status bit 63.
- R7: Writing the data-size register while the output FIFO count is not zero sets status bit 57.
- R8: A done event while the input FIFO count is not zero sets status bit 61.
- R9: A pop of an empty FIFO sets status bit 62 for the input FIFO and bit 58 for the output FIFO.
- R10: A push to a full FIFO sets status bit 59 for the input FIFO (full at 32 entries, 256 bytes) and bit 55 for the output FIFO (full at 16 entries by default). A push below full sets nothing.
- R11: Status bits stay set until the host writes a one to the same bit at offset 2. A new detection in the same cycle as the clear wins, and the bit stays set.
- R12: The mask register at offset 3 stores only bits 55 to 63, and all its other bits read zero. errIrq and engineHalt are high exactly while some status bit has its mask bit clear, so masking a recorded error drops them and unmasking it raises them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W (4) | Host word offset within the window |
| hostWrData | input | 64 | Host write data |
| hostRdData | output | 64 | Read data for hostAddr (combinational) |
| inPush | input | 1 | Input FIFO push strobe |
| inPop | input | 1 | Input FIFO pop strobe |
| inCount | input | clog2(IN_DEPTH+1) | Input FIFO occupancy |
| outPush | input | 1 | Output FIFO push strobe |
| outPop | input | 1 | Output FIFO pop strobe |
| outCount | input | clog2(OUT_DEPTH+1) | Output FIFO occupancy |
| doneEvt | input | 1 | Processing-done event, one cycle |
| errIrq | output | 1 | Error interrupt |
| engineHalt | output | 1 | Halt request to the processing engine |

## Verification
On every cycle the assertions check the following: reset leaves both registers clean, a masked error never appears in the status, any newly recorded error comes with interrupt and halt, status bits fall only under a matching write-one-to-clear, and the data-size, input underflow, input overflow and address detections fire. The bench's reference model follows the status, mask and interrupt on every clock across all nine detections. Some behaviours show up only in the directed scenarios: a detection winning over a clear in the same cycle, the drop and return of the interrupt as a recorded bit is masked and unmasked, the mask register keeping only its nine bits on readback, and stimulus one count short of full or with a legal value raising nothing.

// File: rtl/eu_err_pkg.sv
package eu_err_pkg;
  localparam int REG_W   = 64;
  localparam int ERR_N   = 9;
  localparam int ERR_LSB = 55;

  // Bit index of each error inside the nine-bit field (add ERR_LSB for the register bit)
  localparam int E_OUT_OVF = 0;
  localparam int E_DSIZE   = 1;
  localparam int E_OUT_ERR = 2;
  localparam int E_OUT_UNF = 3;
  localparam int E_IN_OVF  = 4;
  localparam int E_MODE    = 5;
  localparam int E_IN_ERR  = 6;
  localparam int E_IN_UNF  = 7;
  localparam int E_ADDR    = 8;

  // Word offsets of the mapped registers
  localparam int OFF_MODE   = 0;
  localparam int OFF_DSIZE  = 1;
  localparam int OFF_STATUS = 2;
  localparam int OFF_MASK   = 3;
  localparam int NUM_REGS   = 4;

  typedef struct packed {
    logic [ERR_N-1:0] hit;     // raw detections this cycle
    logic             clrWr;   // write-one-to-clear to the status register
    logic             maskWr;  // write to the mask register
    logic [ERR_N-1:0] wrBits;  // error field of the host write data
  } ctlStrobeT;
endpackage

// File: rtl/eu_err_fifo_watch.sv
module eu_err_fifo_watch #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             push,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  output logic             underflow,
  output logic             overflow,
  output logic             notEmpty
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  always_comb begin
    notEmpty  = (count != '0);
    underflow = pop && !notEmpty;
    overflow  = push && (count >= FULL_CNT);
  end
endmodule

// File: rtl/eu_err_ctl.sv
module eu_err_ctl
  import eu_err_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          IN_DEPTH   = 32,
  parameter int          OUT_DEPTH  = 16,
  parameter logic [63:0] MODE_VALID = 64'h7,
  localparam int         IN_CNT_W   = $clog2(IN_DEPTH + 1),
  localparam int         OUT_CNT_W  = $clog2(OUT_DEPTH + 1)
) (
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [REG_W-1:0]     hostWrData,
  input  logic                 inPush,
  input  logic                 inPop,
  input  logic [IN_CNT_W-1:0]  inCount,
  input  logic                 outPush,
  input  logic                 outPop,
  input  logic [OUT_CNT_W-1:0] outCount,
  input  logic                 doneEvt,
  output ctlStrobeT            strb
);
  localparam int ALIGN_W = $clog2(REG_W);

  logic inUnf, inOvf, inBusy;
  logic outUnf, outOvf, outBusy;
  logic mapped, wrMode, wrSize;

  eu_err_fifo_watch #(.DEPTH(IN_DEPTH), .CNT_W(IN_CNT_W)) u_inWatch (
    .push(inPush), .pop(inPop), .count(inCount),
    .underflow(inUnf), .overflow(inOvf), .notEmpty(inBusy)
  );

  eu_err_fifo_watch #(.DEPTH(OUT_DEPTH), .CNT_W(OUT_CNT_W)) u_outWatch (
    .push(outPush), .pop(outPop), .count(outCount),
    .underflow(outUnf), .overflow(outOvf), .notEmpty(outBusy)
  );

  always_comb begin
    mapped = (hostAddr < ADDR_W'(NUM_REGS));
    wrMode = hostWrEn && (hostAddr == ADDR_W'(OFF_MODE));
    wrSize = hostWrEn && (hostAddr == ADDR_W'(OFF_DSIZE));

    strb.hit            = '0;
    strb.hit[E_ADDR]    = (hostWrEn || hostRdEn) && !mapped;
    strb.hit[E_MODE]    = wrMode && ((hostWrData & ~MODE_VALID) != '0);
    strb.hit[E_DSIZE]   = wrSize && (hostWrData[ALIGN_W-1:0] != '0);
    strb.hit[E_OUT_ERR] = wrSize && outBusy;
    strb.hit[E_IN_ERR]  = doneEvt && inBusy;
    strb.hit[E_IN_UNF]  = inUnf;
    strb.hit[E_IN_OVF]  = inOvf;
    strb.hit[E_OUT_UNF] = outUnf;
    strb.hit[E_OUT_OVF] = outOvf;

    strb.clrWr  = hostWrEn && (hostAddr == ADDR_W'(OFF_STATUS));
    strb.maskWr = hostWrEn && (hostAddr == ADDR_W'(OFF_MASK));
    strb.wrBits = hostWrData[ERR_LSB +: ERR_N];
  end
endmodule

// File: rtl/eu_err_dp.sv
module eu_err_dp
  import eu_err_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobeT         strb,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [REG_W-1:0]  hostRdData,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  maskQ,
  output logic              errIrq,
  output logic              engineHalt
);
  logic [ERR_N-1:0] statusBits;
  logic [ERR_N-1:0] maskBits;
  logic [ERR_N-1:0] clrBits;
  logic             anyLive;

  always_comb clrBits = strb.clrWr ? strb.wrBits : '0;

  // Detection uses the mask held before this edge; a set beats a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusBits <= '0;
      maskBits   <= '0;
    end else begin
      statusBits <= (statusBits & ~clrBits) | (strb.hit & ~maskBits);
      if (strb.maskWr) maskBits <= strb.wrBits;
    end
  end

  always_comb begin
    statusQ = {statusBits, {ERR_LSB{1'b0}}};
    maskQ   = {maskBits, {ERR_LSB{1'b0}}};
    anyLive = |(statusBits & ~maskBits);
    errIrq     = anyLive;
    engineHalt = anyLive;
    case (hostAddr)
      ADDR_W'(OFF_STATUS): hostRdData = statusQ;
      ADDR_W'(OFF_MASK):   hostRdData = maskQ;
      default:             hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/eu_err_mon.sv
module eu_err_mon
  import eu_err_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          IN_DEPTH   = 32,
  parameter int          OUT_DEPTH  = 16,
  parameter logic [63:0] MODE_VALID = 64'h7,
  localparam int         IN_CNT_W   = $clog2(IN_DEPTH + 1),
  localparam int         OUT_CNT_W  = $clog2(OUT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [63:0]          hostWrData,
  output logic [63:0]          hostRdData,
  input  logic                 inPush,
  input  logic                 inPop,
  input  logic [IN_CNT_W-1:0]  inCount,
  input  logic                 outPush,
  input  logic                 outPop,
  input  logic [OUT_CNT_W-1:0] outCount,
  input  logic                 doneEvt,
  output logic                 errIrq,
  output logic                 engineHalt
);
  ctlStrobeT        strb;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] maskQ;

  eu_err_ctl #(
    .ADDR_W(ADDR_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .MODE_VALID(MODE_VALID)
  ) u_ctl (
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .inPush(inPush), .inPop(inPop), .inCount(inCount),
    .outPush(outPush), .outPop(outPop), .outCount(outCount),
    .doneEvt(doneEvt), .strb(strb)
  );

  eu_err_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .hostAddr(hostAddr),
    .hostRdData(hostRdData), .statusQ(statusQ), .maskQ(maskQ),
    .errIrq(errIrq), .engineHalt(engineHalt)
  );
endmodule

// File: rtl/eu_err_chk.sv
module eu_err_chk #(
  parameter int ADDR_W   = 4,
  parameter int IN_DEPTH = 32,
  parameter int IN_CNT_W = $clog2(IN_DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hostWrEn,
  input logic                hostRdEn,
  input logic [ADDR_W-1:0]   hostAddr,
  input logic [63:0]         hostWrData,
  input logic                inPush,
  input logic                inPop,
  input logic [IN_CNT_W-1:0] inCount,
  input logic                errIrq,
  input logic                engineHalt,
  input logic [63:0]         statusQ,
  input logic [63:0]         maskQ
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (statusQ == 64'd0) && (maskQ == 64'd0) && !errIrq && !engineHalt); // R1

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusQ & ~$past(statusQ) & $past(maskQ)) == 64'd0)); // R2

  AST_NEW_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusQ & ~$past(statusQ)) != 64'd0) |-> (errIrq && engineHalt)); // R3

  AST_DSIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWrEn && hostAddr == ADDR_W'(1) && hostWrData[5:0] != 6'd0 && !maskQ[56])
    |=> statusQ[56]); // R4

  AST_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((hostWrEn || hostRdEn) && hostAddr >= ADDR_W'(4) && !maskQ[63]) |=> statusQ[63]); // R6

  AST_IN_UNF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inPop && inCount == '0 && !maskQ[62]) |=> statusQ[62]); // R9

  AST_IN_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inPush && inCount == IN_CNT_W'(IN_DEPTH) && !maskQ[59]) |=> statusQ[59]); // R10

  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(statusQ) & ~statusQ &
              ~(($past(hostWrEn) && $past(hostAddr) == ADDR_W'(2)) ? $past(hostWrData) : 64'd0))
              == 64'd0)); // R11
endmodule

bind eu_err_mon eu_err_chk #(
  .ADDR_W(ADDR_W), .IN_DEPTH(IN_DEPTH), .IN_CNT_W(IN_CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .inPush(inPush), .inPop(inPop),
  .inCount(inCount), .errIrq(errIrq), .engineHalt(engineHalt),
  .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/eu_err_mon_tb.sv
`timescale 1ns/1ps
module eu_err_mon_tb;
  localparam logic [63:0] ERRS = 64'hFF80_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [63:0] hostWrData = '0;
  logic [63:0] hostRdData;
  logic        inPush = 1'b0, inPop = 1'b0, outPush = 1'b0, outPop = 1'b0, doneEvt = 1'b0;
  logic [5:0]  inCount = '0;
  logic [4:0]  outCount = '0;
  logic        errIrq, engineHalt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] mStat = '0;
  logic [63:0] mMask = '0;

  always #10 clk = ~clk;

  eu_err_mon u_dut (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .inPush(inPush), .inPop(inPop), .inCount(inCount),
    .outPush(outPush), .outPop(outPop), .outCount(outCount),
    .doneEvt(doneEvt), .errIrq(errIrq), .engineHalt(engineHalt)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    logic [63:0] found;
    logic [63:0] nxt;
    if (!rst_n) begin
      mStat <= '0;
      mMask <= '0;
    end else begin
      found = '0;
      if ((hostWrEn || hostRdEn) && int'(hostAddr) > 3) found[63] = 1'b1;
      if (hostWrEn && hostAddr == 0 && hostWrData > 64'd7) found[60] = 1'b1;
      if (hostWrEn && hostAddr == 1) begin
        if (hostWrData % 64 != 0) found[56] = 1'b1;
        if (outCount > 0) found[57] = 1'b1;
      end
      if (doneEvt && inCount > 0) found[61] = 1'b1;
      if (inPop && inCount == 0) found[62] = 1'b1;
      if (inPush && inCount == 32) found[59] = 1'b1;
      if (outPop && outCount == 0) found[58] = 1'b1;
      if (outPush && outCount == 16) found[55] = 1'b1;
      nxt = mStat;
      if (hostWrEn && hostAddr == 2) nxt = nxt & ~(hostWrData & ERRS);
      nxt = nxt | (found & ~mMask);
      mStat <= nxt;
      if (hostWrEn && hostAddr == 3) mMask <= hostWrData & ERRS;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R12 model irq", {63'd0, errIrq}, {63'd0, (mStat & ~mMask) != 0});
      check("R12 model halt", {63'd0, engineHalt}, {63'd0, (mStat & ~mMask) != 0});
    end
  end

  task automatic step();
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0; inPush = 1'b0; inPop = 1'b0;
    outPush = 1'b0; outPop = 1'b0; doneEvt = 1'b0;
  endtask

  task automatic hostWr(logic [3:0] a, logic [63:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    step();
  endtask

  task automatic readChk(logic [3:0] a, logic [63:0] exp, string tag);
    hostRdEn = 1'b1; hostAddr = a;
    #2;
    check(tag, hostRdData, exp);
    check({tag, " model"}, hostRdData, (a == 2) ? mStat : (a == 3) ? mMask : 64'd0);
    step();
  endtask

  task automatic pinsChk(logic exp, string tag);
    check(tag, {62'd0, errIrq, engineHalt}, {62'd0, exp, exp});
  endtask

  task automatic clearAll();
    hostWr(4'd2, ERRS);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    pinsChk(1'b0, "R1 pins");
    readChk(4'd2, 64'd0, "R1 status");
    readChk(4'd3, 64'd0, "R1 mask");

    // R4 data size, R3 pins
    hostWr(4'd1, 64'd128);
    readChk(4'd2, 64'd0, "R4 aligned size");
    hostWr(4'd1, 64'd100);
    pinsChk(1'b1, "R3 pins after error");
    readChk(4'd2, 64'd1 << 56, "R4 size error");
    hostWr(4'd2, 64'd1 << 56);
    readChk(4'd2, 64'd0, "R11 w1c clear");
    pinsChk(1'b0, "R11 pins after clear");

    // R5 mode
    hostWr(4'd0, 64'd5);
    readChk(4'd2, 64'd0, "R5 legal mode");
    hostWr(4'd0, 64'd8);
    readChk(4'd2, 64'd1 << 60, "R5 reserved bit");
    clearAll();

    // R6 address
    hostRdEn = 1'b1; hostAddr = 4'd9; step();
    readChk(4'd2, 64'd1 << 63, "R6 read unmapped");
    clearAll();
    hostWr(4'd15, 64'd0);
    readChk(4'd2, 64'd1 << 63, "R6 write unmapped");
    clearAll();

    // R7 output FIFO leftover at size write
    outCount = 5'd3;
    hostWr(4'd1, 64'd64);
    readChk(4'd2, 64'd1 << 57, "R7 leftover output");
    clearAll();
    outCount = 5'd0;

    // R8 input FIFO leftover at done
    inCount = 6'd2; doneEvt = 1'b1; step();
    readChk(4'd2, 64'd1 << 61, "R8 leftover input");
    clearAll();
    inCount = 6'd0; doneEvt = 1'b1; step();
    readChk(4'd2, 64'd0, "R8 empty at done");

    // R9 underflow
    inPop = 1'b1; step();
    readChk(4'd2, 64'd1 << 62, "R9 input underflow");
    clearAll();
    outPop = 1'b1; step();
    readChk(4'd2, 64'd1 << 58, "R9 output underflow");
    clearAll();

    // R10 overflow
    inCount = 6'd31; inPush = 1'b1; step();
    readChk(4'd2, 64'd0, "R10 input below full");
    inCount = 6'd32; inPush = 1'b1; step();
    readChk(4'd2, 64'd1 << 59, "R10 input overflow");
    clearAll();
    inCount = 6'd0;
    outCount = 5'd16; outPush = 1'b1; step();
    readChk(4'd2, 64'd1 << 55, "R10 output overflow");
    clearAll();
    outCount = 5'd0;

    // R11 set wins over same-cycle clear
    inPop = 1'b1; step();
    inPop = 1'b1; hostWr(4'd2, 64'd1 << 62);
    readChk(4'd2, 64'd1 << 62, "R11 set beats clear");
    clearAll();

    // R12 mask layout and R2 masked errors
    hostWr(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    readChk(4'd3, ERRS, "R12 mask readback");
    hostWr(4'd3, 64'd1 << 56);
    hostWr(4'd1, 64'd100);
    pinsChk(1'b0, "R2 masked pins");
    readChk(4'd2, 64'd0, "R2 masked status");
    hostWr(4'd3, 64'd0);

    // R12 interrupt follows mask of a recorded bit
    inPop = 1'b1; step();
    pinsChk(1'b1, "R12 pins raised");
    hostWr(4'd3, 64'd1 << 62);
    pinsChk(1'b0, "R12 pins masked");
    readChk(4'd2, 64'd1 << 62, "R12 status kept");
    hostWr(4'd3, 64'd0);
    pinsChk(1'b1, "R12 pins unmasked");
    clearAll();
    pinsChk(1'b0, "R12 pins cleared");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule